// File: doc/BRIEF.md
# Converter Calibration Sweep Sequencer

This block runs the routing and timing of a converter self-calibration sweep. A precision setpoint DAC (24-bit, two's complement) and a calibration DAC (16-bit, offset binary) receive the same target level at each sweep point. The levels are produced by accumulation: a start code is loaded and a step code is added after every point. The default sweep has 11 points. For a -10 V to +10 V sweep in 2 V steps, software supplies the codes for -10 V and for a 2 V step in each DAC's format. The sequencer needs no voltage arithmetic of its own.

Each point is measured in two phases. In the first phase, the second current-monitor multiplexer connects ADC2 to the setpoint DAC. After the settling conversions are thrown away, one ADC2 reading is captured and the external reference meter is triggered. In the second phase, all three multiplexers are switched to the calibration DAC. After settling, one reading from each of ADC1, ADC2 and ADC3 is captured. Every result leaves the block as a one-cycle tagged sample that carries its point index. The serial DAC and ADC engines sit outside the block and are reached through handshake ports. Fitting gain and offset is done downstream.

Top module: `cal_sweep_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, all three multiplexer enables, `smp_vld`, `ref_trig` and both DAC write requests are low.
- R2: At point k, the setpoint DAC code is start + k*step modulo 2^24 and the calibration DAC code is start + k*step modulo 2^16. Each write request stays high with a stable code until its own ready is seen. Both DACs must have accepted before the first phase's settling begins.
- R3: From the DAC write of a point until its reference sample, the second current-monitor mux drives address 11 with enable high (input 4, the setpoint DAC). The other two muxes are disabled during this time. Enable low closes no switch, and addresses 00/01/10/11 with enable high select inputs 1/2/3/4.
- R4: In the first phase, the ADC2 conversions seen after both DAC writes are accepted are counted. The first DISCARD of them (default 6) are dropped and the next one is captured.
- R5: The first-phase capture is emitted with tag 1. It is followed in the next cycle by a sample with tag 0 and data 0, with `ref_trig` high in that same cycle.
- R6: In the second phase, both current-monitor muxes drive address 01 (input 2) and the voltage-monitor mux drives address 10 (input 3), all enabled.
- R7: In the second phase, each ADC drops its first DISCARD conversions after rerouting and captures the next one. Once all three are held, they are emitted in three consecutive cycles with tags 2 (ADC1), 3 (ADC2) and 4 (ADC3).
- R8: Every sample carries the index of its point on `smp_idx`, running 0 to NPTS-1. A full sweep yields 5*NPTS samples.
- R9: `done` pulses for one cycle right after the tag-4 sample of the last point, and `busy` is low in that cycle.
- R10: When `abort` is high at a clock edge, the block is idle after that edge: all mux enables are low, no `done` is raised and no further samples appear.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| abort | input | 1 | Stop the sweep and open all muxes |
| sp_start_code | input | SP_W | Setpoint DAC code for point 0 |
| sp_step_code | input | SP_W | Setpoint DAC code increment per point |
| cl_start_code | input | CL_W | Calibration DAC code for point 0 |
| cl_step_code | input | CL_W | Calibration DAC code increment per point |
| sp_wr_valid | output | 1 | Setpoint DAC write request |
| sp_wr_code | output | SP_W | Setpoint DAC code to write |
| sp_wr_ready | input | 1 | Setpoint DAC engine accepts the write |
| cl_wr_valid | output | 1 | Calibration DAC write request |
| cl_wr_code | output | CL_W | Calibration DAC code to write |
| cl_wr_ready | input | 1 | Calibration DAC engine accepts the write |
| adc_cnv_vld | input | 3 | Conversion strobe per ADC (bit 0 = ADC1) |
| adc1_data | input | SAMP_W | ADC1 conversion result |
| adc2_data | input | SAMP_W | ADC2 conversion result |
| adc3_data | input | SAMP_W | ADC3 conversion result |
| mux_c1_addr | output | 2 | First current-monitor mux address |
| mux_c1_en | output | 1 | First current-monitor mux enable |
| mux_c2_addr | output | 2 | Second current-monitor mux address |
| mux_c2_en | output | 1 | Second current-monitor mux enable |
| mux_vm_addr | output | 2 | Voltage-monitor mux address |
| mux_vm_en | output | 1 | Voltage-monitor mux enable |
| ref_trig | output | 1 | External reference meter trigger pulse |
| smp_vld | output | 1 | Tagged sample valid |
| smp_idx | output | IDX_W | Sweep point index of the sample |
| smp_tag | output | 3 | Sample source tag (0 to 4) |
| smp_data | output | SAMP_W | Sample data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench keeps the default build: 11 points, 6 dropped conversions, a 24-bit setpoint code and a 16-bit calibration code. With these values a whole sweep fits in well under a thousand cycles, so every point index, the last-point exit and both code wraps are reached. The three ADCs convert at unequal, unrelated periods, which makes the second-phase wait end on each of them in turn. The DAC ready lines arrive at different times, which exercises the hold-until-accepted rule. Start codes just below full scale force the 24-bit and 16-bit accumulators to wrap partway through a sweep.

// File: rtl/cal_sweep_pkg.sv
package cal_sweep_pkg;

  // Sample source tags
  typedef enum logic [2:0] {
    TAG_REF   = 3'd0,
    TAG_SP_A2 = 3'd1,
    TAG_CL_A1 = 3'd2,
    TAG_CL_A2 = 3'd3,
    TAG_CL_A3 = 3'd4
  } smp_tag_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WRITE, ST_SET1, ST_CAP1, ST_REF,
    ST_SET2, ST_E1, ST_E2, ST_E3
  } seq_st_e;

  typedef struct packed {
    logic       en;
    logic [1:0] addr;
  } mux_ctl_t;

  // Mux input numbers (1..4); 0 means no switch closed
  localparam logic [2:0] MUX_OFF   = 3'd0;
  localparam logic [2:0] IN_SP_C2  = 3'd4;
  localparam logic [2:0] IN_CL_CUR = 3'd2;
  localparam logic [2:0] IN_CL_VM  = 3'd3;

  function automatic mux_ctl_t mux_pick(input logic [2:0] inp);
    mux_ctl_t m;
    if (inp == MUX_OFF) begin
      m.en   = 1'b0;
      m.addr = 2'b00;
    end else begin
      m.en   = 1'b1;
      m.addr = 2'(inp - 3'd1);
    end
    return m;
  endfunction

endpackage

// File: rtl/cal_code_step.sv
module cal_code_step #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] start_code,
  input  logic [W-1:0] step_code,
  output logic [W-1:0] code
);

  logic [W-1:0] code_q;
  logic [W-1:0] code_d;
  logic         code_en;

  assign code_en = load | adv;
  assign code_d  = load ? start_code : (code_q + step_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/cal_settle_cap.sv
module cal_settle_cap #(
  parameter int DW      = 24,
  parameter int DISCARD = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          cnv_vld,
  input  logic [DW-1:0] cnv_data,
  output logic          got,
  output logic [DW-1:0] hold
);

  localparam int CW = (DISCARD > 0) ? $clog2(DISCARD + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          got_q, got_d;
  logic [DW-1:0] hold_q;
  logic          take;

  assign take = arm & cnv_vld & ~got_q & (cnt_q == CW'(DISCARD));

  always_comb begin
    cnt_d = cnt_q;
    got_d = got_q;
    if (!arm) begin
      cnt_d = '0;
      got_d = 1'b0;
    end else if (take) begin
      got_d = 1'b1;
    end else if (cnv_vld && !got_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      got_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      got_q <= got_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (take) hold_q <= cnv_data;
  end

  assign got  = got_q;
  assign hold = hold_q;

endmodule

// File: rtl/cal_sweep_seq.sv
module cal_sweep_seq
  import cal_sweep_pkg::*;
#(
  parameter int SP_W    = 24,
  parameter int CL_W    = 16,
  parameter int SAMP_W  = 24,
  parameter int NPTS    = 11,
  parameter int DISCARD = 6,
  localparam int IDX_W  = (NPTS > 1) ? $clog2(NPTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [SP_W-1:0]   sp_start_code,
  input  logic [SP_W-1:0]   sp_step_code,
  input  logic [CL_W-1:0]   cl_start_code,
  input  logic [CL_W-1:0]   cl_step_code,
  output logic              sp_wr_valid,
  output logic [SP_W-1:0]   sp_wr_code,
  input  logic              sp_wr_ready,
  output logic              cl_wr_valid,
  output logic [CL_W-1:0]   cl_wr_code,
  input  logic              cl_wr_ready,
  input  logic [2:0]        adc_cnv_vld,
  input  logic [SAMP_W-1:0] adc1_data,
  input  logic [SAMP_W-1:0] adc2_data,
  input  logic [SAMP_W-1:0] adc3_data,
  output logic [1:0]        mux_c1_addr,
  output logic              mux_c1_en,
  output logic [1:0]        mux_c2_addr,
  output logic              mux_c2_en,
  output logic [1:0]        mux_vm_addr,
  output logic              mux_vm_en,
  output logic              ref_trig,
  output logic              smp_vld,
  output logic [IDX_W-1:0]  smp_idx,
  output logic [2:0]        smp_tag,
  output logic [SAMP_W-1:0] smp_data,
  output logic              busy,
  output logic              done
);

  localparam int N_ADC = 3;
  localparam logic [IDX_W-1:0] LAST_PT = IDX_W'(NPTS - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] pt_q, pt_d;
  logic             sp_ack_q, sp_ack_d, cl_ack_q, cl_ack_d;
  logic             done_q, done_d;
  logic             code_ld, code_adv;
  logic             sp_ok, cl_ok;

  logic [N_ADC-1:0]  arm;
  logic [N_ADC-1:0]  got;
  logic [SAMP_W-1:0] adc_dat [N_ADC];
  logic [SAMP_W-1:0] hold    [N_ADC];

  // DAC code accumulators
  cal_code_step #(.W(SP_W)) u_sp_code (
    .clk, .rst_n, .load(code_ld), .adv(code_adv),
    .start_code(sp_start_code), .step_code(sp_step_code), .code(sp_wr_code)
  );

  cal_code_step #(.W(CL_W)) u_cl_code (
    .clk, .rst_n, .load(code_ld), .adv(code_adv),
    .start_code(cl_start_code), .step_code(cl_step_code), .code(cl_wr_code)
  );

  // Per-ADC settling discard and capture
  assign adc_dat[0] = adc1_data;
  assign adc_dat[1] = adc2_data;
  assign adc_dat[2] = adc3_data;

  always_comb begin
    arm = '0;
    if (st_q == ST_SET1) arm[1] = 1'b1;
    if (st_q == ST_SET2) arm    = '1;
  end

  for (genvar g = 0; g < N_ADC; g++) begin : g_cap
    cal_settle_cap #(.DW(SAMP_W), .DISCARD(DISCARD)) u_cap (
      .clk, .rst_n,
      .arm(arm[g]),
      .cnv_vld(adc_cnv_vld[g]),
      .cnv_data(adc_dat[g]),
      .got(got[g]),
      .hold(hold[g])
    );
  end

  // DAC write handshake
  assign sp_wr_valid = (st_q == ST_WRITE) & ~sp_ack_q;
  assign cl_wr_valid = (st_q == ST_WRITE) & ~cl_ack_q;
  assign sp_ok = sp_ack_q | (sp_wr_valid & sp_wr_ready);
  assign cl_ok = cl_ack_q | (cl_wr_valid & cl_wr_ready);

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    pt_d     = pt_q;
    code_ld  = 1'b0;
    code_adv = 1'b0;
    done_d   = 1'b0;
    sp_ack_d = 1'b0;
    cl_ack_d = 1'b0;
    if (abort) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_d    = ST_WRITE;
          pt_d    = '0;
          code_ld = 1'b1;
        end
        ST_WRITE: begin
          if (sp_ok && cl_ok) begin
            st_d = ST_SET1;
          end else begin
            sp_ack_d = sp_ok;
            cl_ack_d = cl_ok;
          end
        end
        ST_SET1: if (got[1]) st_d = ST_CAP1;
        ST_CAP1: st_d = ST_REF;
        ST_REF:  st_d = ST_SET2;
        ST_SET2: if (&got) st_d = ST_E1;
        ST_E1:   st_d = ST_E2;
        ST_E2:   st_d = ST_E3;
        ST_E3: begin
          if (pt_q == LAST_PT) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d     = ST_WRITE;
            pt_d     = pt_q + 1'b1;
            code_adv = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pt_q     <= '0;
      sp_ack_q <= 1'b0;
      cl_ack_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      pt_q     <= pt_d;
      sp_ack_q <= sp_ack_d;
      cl_ack_q <= cl_ack_d;
      done_q   <= done_d;
    end
  end

  // Multiplexer routing per phase
  mux_ctl_t c1, c2, vm;
  always_comb begin
    c1 = mux_pick(MUX_OFF);
    c2 = mux_pick(MUX_OFF);
    vm = mux_pick(MUX_OFF);
    case (st_q)
      ST_WRITE, ST_SET1, ST_CAP1, ST_REF: c2 = mux_pick(IN_SP_C2);
      ST_SET2, ST_E1, ST_E2, ST_E3: begin
        c1 = mux_pick(IN_CL_CUR);
        c2 = mux_pick(IN_CL_CUR);
        vm = mux_pick(IN_CL_VM);
      end
      default: ;
    endcase
  end

  assign mux_c1_addr = c1.addr;
  assign mux_c1_en   = c1.en;
  assign mux_c2_addr = c2.addr;
  assign mux_c2_en   = c2.en;
  assign mux_vm_addr = vm.addr;
  assign mux_vm_en   = vm.en;

  // Tagged sample output
  always_comb begin
    smp_vld  = 1'b1;
    smp_tag  = TAG_REF;
    smp_data = '0;
    case (st_q)
      ST_CAP1: begin smp_tag = TAG_SP_A2; smp_data = hold[1]; end
      ST_REF:  begin smp_tag = TAG_REF;   smp_data = '0;      end
      ST_E1:   begin smp_tag = TAG_CL_A1; smp_data = hold[0]; end
      ST_E2:   begin smp_tag = TAG_CL_A2; smp_data = hold[1]; end
      ST_E3:   begin smp_tag = TAG_CL_A3; smp_data = hold[2]; end
      default: smp_vld = 1'b0;
    endcase
  end

  assign smp_idx  = pt_q;
  assign ref_trig = (st_q == ST_REF);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/cal_sweep_seq_chk.sv
module cal_sweep_seq_chk #(
  parameter int SP_W   = 24,
  parameter int CL_W   = 16,
  parameter int SAMP_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              sp_wr_valid,
  input logic [SP_W-1:0]   sp_wr_code,
  input logic              sp_wr_ready,
  input logic              cl_wr_valid,
  input logic [CL_W-1:0]   cl_wr_code,
  input logic              cl_wr_ready,
  input logic [1:0]        mux_c1_addr,
  input logic              mux_c1_en,
  input logic [1:0]        mux_c2_addr,
  input logic              mux_c2_en,
  input logic [1:0]        mux_vm_addr,
  input logic              mux_vm_en,
  input logic              ref_trig,
  input logic              smp_vld,
  input logic [2:0]        smp_tag,
  input logic [SAMP_W-1:0] smp_data,
  input logic              busy,
  input logic              done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mux_c1_en && !mux_c2_en && !mux_vm_en && !smp_vld &&
               !ref_trig && !sp_wr_valid && !cl_wr_valid));

  // R2
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_valid && !sp_wr_ready && !abort) |=> (sp_wr_valid && $stable(sp_wr_code)));

  // R2
  cl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_wr_valid && !cl_wr_ready && !abort) |=> (cl_wr_valid && $stable(cl_wr_code)));

  // R3
  ph1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mux_c1_en) |-> (mux_c2_en && mux_c2_addr == 2'b11 && !mux_vm_en));

  // R6
  ph2_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_c1_en |-> (mux_c1_addr == 2'b01 && mux_c2_en && mux_c2_addr == 2'b01 &&
                   mux_vm_en && mux_vm_addr == 2'b10));

  // R5
  ref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_tag == 3'd1 && !abort) |=>
      (ref_trig && smp_vld && smp_tag == 3'd0 && smp_data == '0));

  // R5
  trig_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_trig |-> (smp_vld && smp_tag == 3'd0));

  // R7
  cl_order_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_tag == 3'd2 && !abort) |=> (smp_vld && smp_tag == 3'd3));

  // R7
  cl_order_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_tag == 3'd3 && !abort) |=> (smp_vld && smp_tag == 3'd4));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(smp_vld) && $past(smp_tag) == 3'd4));

  // R10
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));

endmodule

bind cal_sweep_seq cal_sweep_seq_chk #(
  .SP_W(SP_W), .CL_W(CL_W), .SAMP_W(SAMP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .abort(abort),
  .sp_wr_valid(sp_wr_valid), .sp_wr_code(sp_wr_code), .sp_wr_ready(sp_wr_ready),
  .cl_wr_valid(cl_wr_valid), .cl_wr_code(cl_wr_code), .cl_wr_ready(cl_wr_ready),
  .mux_c1_addr(mux_c1_addr), .mux_c1_en(mux_c1_en),
  .mux_c2_addr(mux_c2_addr), .mux_c2_en(mux_c2_en),
  .mux_vm_addr(mux_vm_addr), .mux_vm_en(mux_vm_en),
  .ref_trig(ref_trig), .smp_vld(smp_vld), .smp_tag(smp_tag), .smp_data(smp_data),
  .busy(busy), .done(done)
);

// File: tb/cal_sweep_seq_tb_top.sv
module cal_sweep_seq_tb_top;

  localparam int NPTS = 11;
  localparam int DISC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [23:0] sp_start_code = '0, sp_step_code = '0;
  logic [15:0] cl_start_code = '0, cl_step_code = '0;
  logic        sp_wr_valid, cl_wr_valid;
  logic [23:0] sp_wr_code;
  logic [15:0] cl_wr_code;
  logic        sp_wr_ready = 1'b0, cl_wr_ready = 1'b0;
  logic [2:0]  adc_cnv_vld = '0;
  logic [23:0] adc1_data = '0, adc2_data = '0, adc3_data = '0;
  logic [1:0]  mux_c1_addr, mux_c2_addr, mux_vm_addr;
  logic        mux_c1_en, mux_c2_en, mux_vm_en;
  logic        ref_trig, smp_vld, busy, done;
  logic [3:0]  smp_idx;
  logic [2:0]  smp_tag;
  logic [23:0] smp_data;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_smp = 0;
  int n_done = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cal_sweep_seq #(.NPTS(NPTS), .DISCARD(DISC)) dut_i (
    .clk, .rst_n, .start, .abort,
    .sp_start_code, .sp_step_code, .cl_start_code, .cl_step_code,
    .sp_wr_valid, .sp_wr_code, .sp_wr_ready,
    .cl_wr_valid, .cl_wr_code, .cl_wr_ready,
    .adc_cnv_vld, .adc1_data, .adc2_data, .adc3_data,
    .mux_c1_addr, .mux_c1_en, .mux_c2_addr, .mux_c2_en, .mux_vm_addr, .mux_vm_en,
    .ref_trig, .smp_vld, .smp_idx, .smp_tag, .smp_data, .busy, .done
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Free-running stimulus: ADCs at unrelated periods, staggered DAC readiness
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    adc_cnv_vld[0] = (cyc % 5) == 1;
    adc_cnv_vld[1] = (cyc % 3) == 0;
    adc_cnv_vld[2] = (cyc % 4) == 3;
    adc1_data = {4'h1, 20'(cyc)};
    adc2_data = {4'h2, 20'(cyc)};
    adc3_data = {4'h3, 20'(cyc)};
    sp_wr_ready = (cyc % 3) == 2;
    cl_wr_ready = (cyc % 4) == 0;
  end

  // Behavioural reference: phase number, counters and captured values
  int          ms, mpt;
  logic [23:0] msp;
  logic [15:0] mcl;
  bit          msa, mca, mdone;
  int          mcnt [3];
  bit          mgot [3];
  logic [23:0] mhold [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mpt = 0; msp = '0; mcl = '0; msa = 0; mca = 0; mdone = 0;
      for (int k = 0; k < 3; k++) begin mcnt[k] = 0; mgot[k] = 0; mhold[k] = '0; end
    end else begin : step
      bit          gold [3];
      logic [23:0] din [3];
      bit          spok, clok, armk;
      din[0] = adc1_data; din[1] = adc2_data; din[2] = adc3_data;
      for (int k = 0; k < 3; k++) gold[k] = mgot[k];
      // R4 / R7: drop DISC conversions after the route is settled, keep the next
      for (int k = 0; k < 3; k++) begin
        armk = (ms == 2 && k == 1) || (ms == 5);
        if (!armk) begin
          mcnt[k] = 0; mgot[k] = 0;
        end else if (adc_cnv_vld[k] && !mgot[k]) begin
          if (mcnt[k] == DISC) begin mhold[k] = din[k]; mgot[k] = 1; end
          else mcnt[k]++;
        end
      end
      spok = msa || (ms == 1 && sp_wr_ready);
      clok = mca || (ms == 1 && cl_wr_ready);
      mdone = 0;
      if (abort) begin
        ms = 0; msa = 0; mca = 0;                     // R10
      end else begin
        case (ms)
          0: if (start) begin ms = 1; mpt = 0; msp = sp_start_code; mcl = cl_start_code; end
          1: if (spok && clok) begin ms = 2; msa = 0; mca = 0; end
             else begin msa = spok; mca = clok; end
          2: if (gold[1]) ms = 3;
          3: ms = 4;
          4: ms = 5;
          5: if (gold[0] && gold[1] && gold[2]) ms = 6;
          6: ms = 7;
          7: ms = 8;
          8: if (mpt == NPTS - 1) begin ms = 0; mdone = 1; end
             else begin mpt++; msp = msp + sp_step_code; mcl = mcl + cl_step_code; ms = 1; end
          default: ms = 0;                            // R11: start outside 0 is ignored
        endcase
      end
    end
  end

  // Every-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin : cmp
      bit   ph1, ph2, ev;
      int   et;
      logic [23:0] ed;
      ph1 = (ms >= 1 && ms <= 4);
      ph2 = (ms >= 5);
      chk("R1 busy", 64'(busy), 64'(ms != 0));
      chk("R9 done", 64'(done), 64'(mdone));
      chk("R2 sp_wr_valid", 64'(sp_wr_valid), 64'(ms == 1 && !msa));
      chk("R2 cl_wr_valid", 64'(cl_wr_valid), 64'(ms == 1 && !mca));
      if (ms == 1) begin
        chk("R2 sp code", 64'(sp_wr_code), 64'(msp));
        chk("R2 cl code", 64'(cl_wr_code), 64'(mcl));
      end
      chk("R3 c2 mux", 64'({mux_c2_en, mux_c2_addr}),
          64'(ph1 ? 3'b111 : (ph2 ? 3'b101 : 3'b000)));
      chk("R6 c1 mux", 64'({mux_c1_en, ph2 ? mux_c1_addr : 2'b00}), 64'(ph2 ? 3'b101 : 3'b000));
      chk("R6 vm mux", 64'({mux_vm_en, ph2 ? mux_vm_addr : 2'b00}), 64'(ph2 ? 3'b110 : 3'b000));
      chk("R5 ref_trig", 64'(ref_trig), 64'(ms == 4));
      ev = (ms == 3 || ms == 4 || ms >= 6);
      chk("R7 smp_vld", 64'(smp_vld), 64'(ev));
      if (ev) begin
        case (ms)
          3: begin et = 1; ed = mhold[1]; end
          4: begin et = 0; ed = '0; end
          6: begin et = 2; ed = mhold[0]; end
          7: begin et = 3; ed = mhold[1]; end
          default: begin et = 4; ed = mhold[2]; end
        endcase
        chk("R7 smp_tag", 64'(smp_tag), 64'(et));
        chk("R4 smp_data", 64'(smp_data), 64'(ed));
        chk("R8 smp_idx", 64'(smp_idx), 64'(mpt));
      end
      if (smp_vld) n_smp++;
      if (done) n_done++;
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R9 sweep finished", 64'(0), 64'(1));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    // Sweep codes for -10 V and a 2 V step in each DAC's format
    sp_start_code = 24'h804168; sp_step_code = 24'h198C85;
    cl_start_code = 16'h199A;   cl_step_code = 16'h147B;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset busy", 64'(busy), 64'(0));
    chk("R1 reset mux enables", 64'({mux_c1_en, mux_c2_en, mux_vm_en}), 64'(0));
    chk("R1 reset smp_vld", 64'(smp_vld), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Full sweep
    n_smp = 0; n_done = 0;
    pulse_start();
    wait_done();
    @(negedge clk);
    chk("R8 sample count", 64'(n_smp), 64'(5 * NPTS));
    chk("R9 done count", 64'(n_done), 64'(1));

    // Abort mid-sweep at point 2
    n_done = 0;
    pulse_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (smp_vld && smp_idx == 4'd2 && smp_tag == 3'd1) break;
    end
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R10 busy after abort", 64'(busy), 64'(0));
    chk("R10 muxes open", 64'({mux_c1_en, mux_c2_en, mux_vm_en}), 64'(0));
    n_smp = 0;
    repeat (40) @(negedge clk);
    chk("R10 no samples", 64'(n_smp), 64'(0));
    chk("R10 no done", 64'(n_done), 64'(0));

    // Wrapping codes, plus a start pulse while busy
    sp_start_code = 24'h7FFFF0; sp_step_code = 24'h000010;
    cl_start_code = 16'hFFF0;   cl_step_code = 16'h0008;
    n_smp = 0; n_done = 0;
    pulse_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (smp_vld && smp_idx == 4'd1) break;
    end
    start = 1'b1;                                      // R11
    @(negedge clk); start = 1'b0;
    chk("R11 busy kept", 64'(busy), 64'(1));
    wait_done();
    @(negedge clk);
    chk("R11 sample count", 64'(n_smp), 64'(5 * NPTS));
    chk("R11 done count", 64'(n_done), 64'(1));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule